// File: doc/BRIEF.md
# Two-Class Credit Shaper for a Transmit Port

This block paces the two most urgent traffic classes of an Ethernet transmit port so that each gets no more than its configured share of the line rate. Each shaped class keeps a signed credit counter. The counter rises every clock while the class has frames waiting and is not sending. It falls every clock while the class is on the wire. A class may begin a new frame only when its credit is zero or more. The downstream frame scheduler reads one eligibility bit per class, together with the current credit value.

Software programs each class through a single write port. A write carries an enable flag, a bandwidth share as an integer percent of the line rate, and a credit ceiling. The block refuses any write that would break its rules:
- the enabled shares must add up to less than 100;
- the second class may be enabled only while the first class is enabled;
- the first class may be turned off only after the second class is off.

A refused write leaves every setting as it was and raises a one-cycle refusal pulse. The link speed input sets how large each per-cycle credit step is.

Top module: `cbs_tc_shaper`

## Requirements
- R1: While `rst_n` is low at a clock edge, both classes become disabled with zero share, zero ceiling and zero credit, `cfg_rej` goes low, and `elig_o` reads 2'b11.
- R2: `spd_sel` picks the step unit: 0 gives 1 (10 Mb/s), 1 gives 10 (100 Mb/s), 2 gives 100 (1000 Mb/s), 3 gives 250 (2500 Mb/s). Any other code gives 1, the same as 10 Mb/s.
- R3: For an enabled class with `q_ne` high and `tx_act` low, credit grows by share×unit per clock and never ends a clock above the class ceiling.
- R4: For an enabled class with `tx_act` high, credit falls by (100−share)×unit per clock. It saturates at −2^(CRED_W−1) and is also held to the ceiling.
- R5: For an enabled class with both `q_ne` and `tx_act` low, a positive credit drops to zero on the next edge. A negative credit rises by share×unit but stops at zero.
- R6: `elig_o[c]` is high when class c is disabled. Otherwise it is high only when `q_ne[c]` is high and the credit of class c is non-negative.
- R7: An accepted write with `cfg_en` low clears the share, the ceiling and the enable of the addressed class. Its credit reads zero from the next edge onward.
- R8: A write with `cfg_en` high is refused when its `cfg_bw`, plus the share of the other class if that class is enabled, is 100 or more.
- R9: Class index 0 is the highest-priority class and index 1 the second. Enabling class 1 while class 0 is disabled is refused. Disabling class 0 while class 1 is enabled is refused.
- R10: `cfg_rej` is high for exactly the cycle after a refused write. A refused write changes no setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spd_sel | input | 3 | Link speed code |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_cls | input | 1 | Addressed class (0 highest priority, 1 second) |
| cfg_en | input | 1 | Enable (1) or disable (0) the class |
| cfg_bw | input | 7 | Share in percent of the line rate |
| cfg_hi | input | CRED_W-1 | Credit ceiling, unsigned |
| cfg_rej | output | 1 | One-cycle pulse after a refused write |
| q_ne | input | 2 | Per-class queue holds a frame |
| tx_act | input | 2 | Per-class frame currently transmitting |
| elig_o | output | 2 | Per-class permission to start a frame |
| credit_o | output | 2*CRED_W | Per-class signed credit, class c in bits [c*CRED_W +: CRED_W] |

## Verification
The assertions take for granted two things: `rst_n` is low at the first clock edge, and the inputs are known at every edge. The falling-credit property also relies on the configuration unit never holding an enabled share of 100 or more, so the send step is always positive. The bench drives inputs only just after a falling edge and keeps the ceiling far inside its field. It deliberately sends shares from 100 to 127 and out-of-order enable and disable writes, so the refusal path runs, rather than assuming software is always well behaved.

// File: rtl/cbs_shaper_pkg.sv
// Shared types and constants for the two-class credit shaper.
// Assumes exactly two shaped classes; index 0 is the most urgent.
package cbs_shaper_pkg;

    localparam int N_CLS  = 2;
    localparam int BW_W   = 7;
    localparam int UNIT_W = 8;
    localparam int PROD_W = BW_W + UNIT_W;
    localparam logic [BW_W-1:0] FULL_PCT = 7'd100;

    typedef enum logic [2:0] {
        SPD_10M  = 3'd0,
        SPD_100M = 3'd1,
        SPD_1G   = 3'd2,
        SPD_2G5  = 3'd3
    } spd_code_e;

    typedef struct packed {
        logic            en;
        logic [BW_W-1:0] bw;
    } cls_cfg_t;

    // Per-cycle step unit for a speed code; unknown codes act as 10 Mb/s.
    function automatic logic [UNIT_W-1:0] unit_of(input logic [2:0] code);
        case (code)
            SPD_100M: unit_of = 8'd10;
            SPD_1G:   unit_of = 8'd100;
            SPD_2G5:  unit_of = 8'd250;
            default:  unit_of = 8'd1;
        endcase
    endfunction

endpackage

// File: rtl/cbs_rate_sel.sv
// Speed decoder: turns the link speed code into the credit step unit.
// Assumes the code is stable around clock edges; purely combinational.
module cbs_rate_sel
    import cbs_shaper_pkg::*;
(
    input  logic [2:0]        spd_sel,
    output logic [UNIT_W-1:0] unit_o
);

    // Map the code to a unit, with a fallback for unlisted codes.
    always_comb begin
        unit_o = unit_of(spd_sel);
    end

endmodule

// File: rtl/cbs_cfg_regs.sv
// Configuration store for both shaped classes.
// Checks each write against the share-sum and enable-order rules, commits
// only legal writes, and pulses a refusal flag for one cycle otherwise.
// Assumes the write fields are valid whenever wr_i is high.
module cbs_cfg_regs
    import cbs_shaper_pkg::*;
#(
    parameter int HI_W = 23
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_i,
    input  logic                       cls_i,
    input  logic                       en_i,
    input  logic [BW_W-1:0]            bw_i,
    input  logic [HI_W-1:0]            hi_i,
    output cls_cfg_t [N_CLS-1:0]       cfg_o,
    output logic [N_CLS-1:0][HI_W-1:0] hi_o,
    output logic                       rej_o
);

    localparam int SUM_W = BW_W + 1;

    cls_cfg_t [N_CLS-1:0]       cfg_q;
    logic [N_CLS-1:0][HI_W-1:0] hi_q;
    logic                       rej_q;
    logic                       other;
    logic [SUM_W-1:0]           share_sum;
    logic                       refuse;

    // Judge the pending write against the current settings.
    always_comb begin
        other     = ~cls_i;
        share_sum = {1'b0, bw_i} + (cfg_q[other].en ? {1'b0, cfg_q[other].bw} : '0);
        refuse    = 1'b0;
        if (en_i) begin
            if (cls_i && !cfg_q[0].en) begin
                refuse = 1'b1;
            end else if (share_sum >= SUM_W'(FULL_PCT)) begin
                refuse = 1'b1;
            end
        end else if (!cls_i && cfg_q[1].en) begin
            refuse = 1'b1;
        end
    end

    // Commit legal writes and record refusals.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            hi_q  <= '0;
            rej_q <= 1'b0;
        end else begin
            rej_q <= wr_i && refuse;
            if (wr_i && !refuse) begin
                if (en_i) begin
                    cfg_q[cls_i].en <= 1'b1;
                    cfg_q[cls_i].bw <= bw_i;
                    hi_q[cls_i]     <= hi_i;
                end else begin
                    cfg_q[cls_i] <= '0;
                    hi_q[cls_i]  <= '0;
                end
            end
        end
    end

    assign cfg_o = cfg_q;
    assign hi_o  = hi_q;
    assign rej_o = rej_q;

    // R8
    share_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[0].en && cfg_q[1].en) |->
            (({1'b0, cfg_q[0].bw} + {1'b0, cfg_q[1].bw}) < SUM_W'(FULL_PCT)));

    // R9
    enable_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[1].en |-> cfg_q[0].en);

    // R10
    refused_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rej_q |-> ($stable(cfg_q) && $stable(hi_q)));

    // R10
    refusal_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && refuse) |=> rej_q);

endmodule

// File: rtl/cbs_credit.sv
// Credit counter for one shaped class.
// Rises by share*unit while waiting, falls by (100-share)*unit while sending,
// snaps to zero from above when the queue drains, and is held to the ceiling.
// Assumes share < 100 whenever enabled (the configuration unit enforces it).
module cbs_credit
    import cbs_shaper_pkg::*;
#(
    parameter int CRED_W = 24,
    parameter int HI_W   = 23
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en_i,
    input  logic [BW_W-1:0]          bw_i,
    input  logic [HI_W-1:0]          hi_i,
    input  logic [UNIT_W-1:0]        unit_i,
    input  logic                     q_ne_i,
    input  logic                     tx_i,
    output logic signed [CRED_W-1:0] cred_o
);

    localparam int XW = CRED_W + 2;

    logic signed [CRED_W-1:0] cred_q;
    logic [PROD_W-1:0]        up_p;
    logic [PROD_W-1:0]        dn_p;
    logic signed [XW-1:0]     cur_x;
    logic signed [XW-1:0]     up_x;
    logic signed [XW-1:0]     dn_x;
    logic signed [XW-1:0]     hi_x;
    logic signed [XW-1:0]     min_x;
    logic signed [XW-1:0]     nxt_x;

    // Form the idle and send steps and extend everything to guard width.
    always_comb begin
        up_p  = {{UNIT_W{1'b0}}, bw_i} * {{BW_W{1'b0}}, unit_i};
        dn_p  = {{UNIT_W{1'b0}}, FULL_PCT - bw_i} * {{BW_W{1'b0}}, unit_i};
        cur_x = XW'(cred_q);
        up_x  = $signed({{(XW - PROD_W){1'b0}}, up_p});
        dn_x  = $signed({{(XW - PROD_W){1'b0}}, dn_p});
        hi_x  = $signed({{(XW - HI_W){1'b0}}, hi_i});
        min_x = $signed({{(XW - CRED_W + 1){1'b1}}, {(CRED_W - 1){1'b0}}});
    end

    // Choose the next credit from the class activity, then apply limits.
    always_comb begin
        if (!en_i) begin
            nxt_x = '0;
        end else if (tx_i) begin
            nxt_x = cur_x - dn_x;
            if (nxt_x < min_x) begin
                nxt_x = min_x;
            end
        end else if (q_ne_i) begin
            nxt_x = cur_x + up_x;
        end else if (cur_x > 0) begin
            nxt_x = '0;
        end else begin
            nxt_x = cur_x + up_x;
            if (nxt_x > 0) begin
                nxt_x = '0;
            end
        end
        if (en_i && (nxt_x > hi_x)) begin
            nxt_x = hi_x;
        end
    end

    // Hold the credit state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cred_q <= '0;
        end else begin
            cred_q <= nxt_x[CRED_W-1:0];
        end
    end

    assign cred_o = cred_q;

    // R3
    ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |=> ($signed({cred_q[CRED_W-1], cred_q}) <= $signed({1'b0, $past(hi_i)})));

    // R4
    send_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && tx_i) |=> (cred_q <= $past(cred_q)));

    // R5
    drain_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !tx_i && !q_ne_i && (cred_q > 0)) |=> (cred_q == '0));

    // R7
    disabled_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (cred_q == '0));

endmodule

// File: rtl/cbs_tc_shaper.sv
// Top of the two-class credit shaper.
// Joins the speed decoder, the configuration store and one credit counter
// per class, and forms the per-class eligibility for the frame scheduler.
// Assumes a synchronous active-low reset and known inputs at each edge.
module cbs_tc_shaper
    import cbs_shaper_pkg::*;
#(
    parameter int CRED_W = 24,
    localparam int HI_W  = CRED_W - 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2:0]              spd_sel,
    input  logic                    cfg_wr,
    input  logic                    cfg_cls,
    input  logic                    cfg_en,
    input  logic [6:0]              cfg_bw,
    input  logic [HI_W-1:0]         cfg_hi,
    output logic                    cfg_rej,
    input  logic [1:0]              q_ne,
    input  logic [1:0]              tx_act,
    output logic [1:0]              elig_o,
    output logic [2*CRED_W-1:0]     credit_o
);

    logic [UNIT_W-1:0]          unit;
    cls_cfg_t [N_CLS-1:0]       cfg;
    logic [N_CLS-1:0][HI_W-1:0] hi;

    cbs_rate_sel u_rate (
        .spd_sel (spd_sel),
        .unit_o  (unit)
    );

    cbs_cfg_regs #(
        .HI_W (HI_W)
    ) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_i  (cfg_wr),
        .cls_i (cfg_cls),
        .en_i  (cfg_en),
        .bw_i  (cfg_bw),
        .hi_i  (cfg_hi),
        .cfg_o (cfg),
        .hi_o  (hi),
        .rej_o (cfg_rej)
    );

    for (genvar c = 0; c < N_CLS; c++) begin : g_cls
        logic signed [CRED_W-1:0] cred;

        cbs_credit #(
            .CRED_W (CRED_W),
            .HI_W   (HI_W)
        ) u_credit (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_i   (cfg[c].en),
            .bw_i   (cfg[c].bw),
            .hi_i   (hi[c]),
            .unit_i (unit),
            .q_ne_i (q_ne[c]),
            .tx_i   (tx_act[c]),
            .cred_o (cred)
        );

        // Permit a start when unshaped, or when waiting with non-negative credit.
        always_comb begin
            elig_o[c] = !cfg[c].en || (q_ne[c] && !cred[CRED_W-1]);
        end

        assign credit_o[c*CRED_W +: CRED_W] = cred;

        // R6
        empty_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg[c].en && !q_ne[c]) |-> !elig_o[c]);

        // R6
        unshaped_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg[c].en |-> elig_o[c]);
    end

endmodule

// File: tb/test_cbs_tc_shaper.sv
// Bench for the two-class credit shaper: a behavioural model updated on each
// rising edge and compared with the design on every falling edge, plus
// directed checks with hand-computed values.
module test_cbs_tc_shaper;

    localparam int CLK_PERIOD = 10;
    localparam int CW = 24;
    localparam int HW = CW - 1;
    localparam int CMIN = -(2 ** (CW - 1));

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [2:0]          spd_sel = '0;
    logic                cfg_wr = 1'b0;
    logic                cfg_cls = 1'b0;
    logic                cfg_en = 1'b0;
    logic [6:0]          cfg_bw = '0;
    logic [HW-1:0]       cfg_hi = '0;
    logic                cfg_rej;
    logic [1:0]          q_ne = '0;
    logic [1:0]          tx_act = '0;
    logic [1:0]          elig_o;
    logic [2*CW-1:0]     credit_o;

    int n_chk = 0;
    int n_fail = 0;
    bit cmp_on = 1'b0;

    // reference model state
    bit m_en [2];
    int m_bw [2];
    int m_hi [2];
    int m_cred [2];
    bit m_rej;
    int m_u;
    int m_nc [2];
    int m_sum;
    bit m_refuse;

    cbs_tc_shaper #(.CRED_W(CW)) i_cbs_tc_shaper (
        .clk      (clk),
        .rst_n    (rst_n),
        .spd_sel  (spd_sel),
        .cfg_wr   (cfg_wr),
        .cfg_cls  (cfg_cls),
        .cfg_en   (cfg_en),
        .cfg_bw   (cfg_bw),
        .cfg_hi   (cfg_hi),
        .cfg_rej  (cfg_rej),
        .q_ne     (q_ne),
        .tx_act   (tx_act),
        .elig_o   (elig_o),
        .credit_o (credit_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int unit_ref(input int code);
        case (code)
            1: return 10;
            2: return 100;
            3: return 250;
            default: return 1;
        endcase
    endfunction

    function automatic int cred_of(input int c);
        logic signed [CW-1:0] v;
        v = credit_o[c*CW +: CW];
        return int'(v);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Reference model: one step per rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_en[c] = 1'b0; m_bw[c] = 0; m_hi[c] = 0; m_cred[c] = 0;
            end
            m_rej = 1'b0;
        end else begin
            m_u = unit_ref(int'(spd_sel));
            for (int c = 0; c < 2; c++) begin
                if (!m_en[c]) m_nc[c] = 0;
                else if (tx_act[c]) begin
                    m_nc[c] = m_cred[c] - (100 - m_bw[c]) * m_u;
                    if (m_nc[c] < CMIN) m_nc[c] = CMIN;
                end else if (q_ne[c]) m_nc[c] = m_cred[c] + m_bw[c] * m_u;
                else if (m_cred[c] > 0) m_nc[c] = 0;
                else begin
                    m_nc[c] = m_cred[c] + m_bw[c] * m_u;
                    if (m_nc[c] > 0) m_nc[c] = 0;
                end
                if (m_en[c] && m_nc[c] > m_hi[c]) m_nc[c] = m_hi[c];
            end
            m_refuse = 1'b0;
            if (cfg_wr) begin
                if (cfg_en) begin
                    m_sum = int'(cfg_bw) + (m_en[1-int'(cfg_cls)] ? m_bw[1-int'(cfg_cls)] : 0);
                    if (cfg_cls && !m_en[0]) m_refuse = 1'b1;
                    else if (m_sum >= 100) m_refuse = 1'b1;
                end else if (!cfg_cls && m_en[1]) m_refuse = 1'b1;
                if (!m_refuse) begin
                    m_en[cfg_cls] = cfg_en;
                    m_bw[cfg_cls] = cfg_en ? int'(cfg_bw) : 0;
                    m_hi[cfg_cls] = cfg_en ? int'(cfg_hi) : 0;
                end
            end
            m_rej = m_refuse;
            for (int c = 0; c < 2; c++) m_cred[c] = m_nc[c];
        end
    end

    // Compare with the model on every falling edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            for (int c = 0; c < 2; c++) begin
                bit e;
                e = !m_en[c] || (q_ne[c] && m_cred[c] >= 0);
                chk(elig_o[c] == e, "R6 eligibility vs model", int'(elig_o[c]), int'(e));
                chk(cred_of(c) == m_cred[c], "R3 R4 R5 credit vs model", cred_of(c), m_cred[c]);
            end
            chk(cfg_rej == m_rej, "R10 refusal pulse vs model", int'(cfg_rej), int'(m_rej));
        end
    end

    // Move to the drive slot just after the next falling edge.
    task automatic tick;
        @(negedge clk);
        #1;
    endtask

    task automatic do_cfg(input bit cls, input bit en, input int bw, input int hi);
        cfg_wr = 1'b1; cfg_cls = cls; cfg_en = en; cfg_bw = 7'(bw); cfg_hi = HW'(hi);
        tick();
        cfg_wr = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        report();
        $finish;
    end

    initial begin
        repeat (3) tick();
        // R1 reset state
        chk(elig_o == 2'b11, "R1 elig after reset", int'(elig_o), 3);
        chk(cred_of(0) == 0 && cred_of(1) == 0, "R1 credit after reset", cred_of(0), 0);
        chk(cfg_rej == 1'b0, "R1 rej after reset", int'(cfg_rej), 0);
        rst_n = 1'b1;
        cmp_on = 1'b1;

        spd_sel = 3'd2; q_ne = 2'b01;
        do_cfg(0, 1, 30, 5000);
        chk(cfg_rej == 1'b0, "R8 legal enable accepted", int'(cfg_rej), 0);
        repeat (4) tick();
        chk(cred_of(0) == 5000, "R3 rise capped at ceiling", cred_of(0), 5000);
        tx_act = 2'b01; tick();
        chk(cred_of(0) == -2000, "R4 send step", cred_of(0), -2000);
        chk(elig_o[0] == 1'b0, "R6 negative credit blocks", int'(elig_o[0]), 0);
        tx_act = 2'b00; tick();
        chk(cred_of(0) == 1000, "R3 idle step", cred_of(0), 1000);
        q_ne = 2'b00; tick();
        chk(cred_of(0) == 0, "R5 positive snaps to zero", cred_of(0), 0);
        chk(elig_o[0] == 1'b0, "R6 empty queue blocks", int'(elig_o[0]), 0);
        q_ne = 2'b01; tx_act = 2'b01; tick();
        q_ne = 2'b00; tx_act = 2'b00; tick();
        chk(cred_of(0) == -4000, "R5 negative recovers", cred_of(0), -4000);
        tick(); tick();
        chk(cred_of(0) == 0, "R5 recovery stops at zero", cred_of(0), 0);
        chk(elig_o[1] == 1'b1, "R6 disabled class eligible", int'(elig_o[1]), 1);

        do_cfg(1, 1, 70, 100);
        chk(cfg_rej == 1'b1, "R8 sum of 100 refused", int'(cfg_rej), 1);
        do_cfg(1, 1, 69, 4000);
        chk(cfg_rej == 1'b0, "R8 sum of 99 accepted", int'(cfg_rej), 0);
        q_ne = 2'b10; tick();
        chk(cred_of(1) == 4000, "R3 class 1 capped", cred_of(1), 4000);
        do_cfg(0, 0, 0, 0);
        chk(cfg_rej == 1'b1, "R9 top disable refused", int'(cfg_rej), 1);
        do_cfg(0, 1, 40, 5000);
        chk(cfg_rej == 1'b1, "R8 rewrite over limit refused", int'(cfg_rej), 1);
        do_cfg(1, 0, 0, 0);
        chk(cfg_rej == 1'b0, "R7 disable accepted", int'(cfg_rej), 0);
        tick();
        chk(cred_of(1) == 0, "R7 credit cleared", cred_of(1), 0);
        chk(elig_o[1] == 1'b1, "R7 disabled class eligible", int'(elig_o[1]), 1);
        do_cfg(0, 0, 0, 0);
        chk(cfg_rej == 1'b0, "R9 top disable accepted", int'(cfg_rej), 0);
        do_cfg(1, 1, 10, 100);
        chk(cfg_rej == 1'b1, "R9 next without top refused", int'(cfg_rej), 1);

        q_ne = 2'b01; spd_sel = 3'd5;
        do_cfg(0, 1, 50, 1000);
        tick();
        chk(cred_of(0) == 50, "R2 unknown code acts as 10M", cred_of(0), 50);
        spd_sel = 3'd1; tick();
        chk(cred_of(0) == 550, "R2 100M unit", cred_of(0), 550);
        spd_sel = 3'd3; tick();
        chk(cred_of(0) == 1000, "R2 2500M unit capped", cred_of(0), 1000);
        spd_sel = 3'd7; tx_act = 2'b01; tick();
        chk(cred_of(0) == 950, "R2 code 7 acts as 10M", cred_of(0), 950);
        tx_act = 2'b00;

        for (int i = 0; i < 4000; i++) begin
            q_ne   = 2'($urandom);
            tx_act = {($urandom % 4) == 0, ($urandom % 4) == 0};
            if ((i % 64) == 0) spd_sel = 3'($urandom % 8);
            cfg_wr  = ($urandom % 16) == 0;
            cfg_cls = 1'($urandom);
            cfg_en  = ($urandom % 4) != 0;
            cfg_bw  = (($urandom % 8) == 0) ? 7'(100 + $urandom % 28) : 7'($urandom % 100);
            cfg_hi  = HW'($urandom % 30000);
            tick();
        end
        cfg_wr = 1'b0;
        tick();
        report();
        $finish;
    end

endmodule